// File: doc/BRIEF.md
# Strobed One-Hot LED Scanner

This block sweeps a single lit bit back and forth across a one-hot LED output. It runs entirely on one system clock. A free-running counter makes a one-cycle strobe that sets the step rate, so the block produces no derived clock. A single raw push-button level enables stepping. That input is asynchronous and may bounce.

Before the button level can gate the scanner, it passes through a flip-flop synchroniser chain and then a stability filter. The filtered level only changes after the synchronised input has held still for a programmable number of cycles. The scanner takes one step on a clock edge only when the filtered enable and the strobe are both high. When the lit bit arrives at either end, it turns around, so each end value appears exactly once per sweep.

Top module: `led_scan_top`

## Requirements
- R1: The LED output is always one-hot. After a synchronous reset it reads 0x01, and the scan direction points toward the most significant bit.
- R2: Each step moves the lit bit exactly one position in the current direction.
- R3: The direction reverses at bit LED_W-1 and again at bit 0. The output repeats every 2*(LED_W-1) steps with the order 01,02,04,…,80,40,…,02,01,02, and no end value is repeated.
- R4: The output changes only on an edge where the filtered enable and the strobe are both high. On every other edge it holds its value.
- R5: The strobe counter counts 0..TICK_MAX and then wraps. The strobe is high for exactly one cycle per wrap. Counting the first edge after reset release as edge 1, the strobe is seen by the scanner on edges n with n mod (TICK_MAX+1) == 1 and n ≥ TICK_MAX+2, so steps are spaced TICK_MAX+1 cycles apart.
- R6: The raw button passes through SYNC_STAGES flip-flops and then the filter. Suppose a new raw level is first sampled on edge k and held for at least STABLE_CNT+1 edges. Then the scanner uses that level from edge k+STABLE_CNT+5 onward. A raw level held for STABLE_CNT edges or fewer never reaches the scanner.
- R7: Reset is synchronous and wins over enable and strobe. It returns the output to 0x01 with the direction upward, and it clears the strobe counter and the enable conditioning.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| btn_raw | input | 1 | Asynchronous, possibly bouncing enable button |
| led | output | LED_W | One-hot scanner output |

## Verification
The bench builds the block with TICK_MAX=4 and STABLE_CNT=3. With these values a strobe arrives every five cycles, and a full 14-step sweep plus the filter latency fit in a few hundred cycles. Bursts of three-cycle button pulses test the filter right at its rejection limit. Every cycle, the expected output is computed from the edge number, the strobe phase and the filter latency, across the start of stepping, its stop and a reset taken while the button is held.

// File: rtl/led_scan_pkg.sv
package led_scan_pkg;
  typedef enum logic {
    DIR_UP   = 1'b0,
    DIR_DOWN = 1'b1
  } scan_dir_e;
endpackage

// File: rtl/led_scan_strobe.sv
module led_scan_strobe #(
  parameter int TICK_MAX = 50_000_000
) (
  input  logic clk,
  input  logic rst,
  output logic strobe
);
  localparam int CW = (TICK_MAX < 1) ? 1 : $clog2(TICK_MAX + 1);
  localparam logic [CW-1:0] LAST = CW'(TICK_MAX);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q  <= '0;
      strobe <= 1'b0;
    end else if (cnt_q == LAST) begin
      cnt_q  <= '0;
      strobe <= 1'b1;
    end else begin
      cnt_q  <= cnt_q + 1'b1;
      strobe <= 1'b0;
    end
  end
endmodule

// File: rtl/led_scan_sync.sv
module led_scan_sync #(
  parameter int STAGES = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic d_async,
  output logic q_sync
);
  logic [STAGES-1:0] chain_q;

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      always_ff @(posedge clk) begin
        if (rst) chain_q[g] <= 1'b0;
        else if (g == 0) chain_q[g] <= d_async;
        else chain_q[g] <= chain_q[(g == 0) ? 0 : g-1];
      end
    end
  endgenerate

  assign q_sync = chain_q[STAGES-1];
endmodule

// File: rtl/led_scan_filter.sv
module led_scan_filter #(
  parameter int STABLE_CNT = 2_500_000
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic dout
);
  localparam int CW = (STABLE_CNT < 1) ? 1 : $clog2(STABLE_CNT + 1);
  localparam logic [CW-1:0] HOLD = CW'(STABLE_CNT);

  logic          prev_q;
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_q <= 1'b0;
      cnt_q  <= '0;
      dout   <= 1'b0;
    end else begin
      prev_q <= din;
      if (din != prev_q) cnt_q <= '0;
      else if (cnt_q != HOLD) cnt_q <= cnt_q + 1'b1;
      if (cnt_q == HOLD) dout <= prev_q;
    end
  end
endmodule

// File: rtl/led_scan_walker.sv
module led_scan_walker
  import led_scan_pkg::*;
#(
  parameter int LED_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             advance,
  output logic [LED_W-1:0] led
);
  localparam logic [LED_W-1:0] START = LED_W'(1);

  scan_dir_e dir_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      led   <= START;
      dir_q <= DIR_UP;
    end else if (advance) begin
      if (dir_q == DIR_UP) begin
        if (led[LED_W-1]) begin
          led   <= led >> 1;
          dir_q <= DIR_DOWN;
        end else begin
          led <= led << 1;
        end
      end else begin
        if (led[0]) begin
          led   <= led << 1;
          dir_q <= DIR_UP;
        end else begin
          led <= led >> 1;
        end
      end
    end
  end
endmodule

// File: rtl/led_scan_top.sv
module led_scan_top #(
  parameter int LED_W       = 8,
  parameter int TICK_MAX    = 50_000_000,
  parameter int STABLE_CNT  = 2_500_000,
  parameter int SYNC_STAGES = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             btn_raw,
  output logic [LED_W-1:0] led
);
  logic strobe;
  logic btn_sync;
  logic btn_clean;

  led_scan_strobe #(.TICK_MAX(TICK_MAX)) u_strobe (
    .clk    (clk),
    .rst    (rst),
    .strobe (strobe)
  );

  led_scan_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rst     (rst),
    .d_async (btn_raw),
    .q_sync  (btn_sync)
  );

  led_scan_filter #(.STABLE_CNT(STABLE_CNT)) u_filter (
    .clk  (clk),
    .rst  (rst),
    .din  (btn_sync),
    .dout (btn_clean)
  );

  led_scan_walker #(.LED_W(LED_W)) u_walker (
    .clk     (clk),
    .rst     (rst),
    .advance (btn_clean & strobe),
    .led     (led)
  );
endmodule

// File: rtl/led_scan_checker.sv
module led_scan_checker #(
  parameter int LED_W = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             strobe,
  input logic             btn_clean,
  input logic [LED_W-1:0] led
);
  localparam logic [LED_W-1:0] TOP = LED_W'(1) << (LED_W - 1);
  localparam logic [LED_W-1:0] BOT = LED_W'(1);

  a_r1_onehot: assert property (@(posedge clk) disable iff (rst)
    $countones(led) == 1);

  a_r7_reset_value: assert property (@(posedge clk)
    rst |=> led == BOT);

  a_r4_hold_idle: assert property (@(posedge clk) disable iff (rst)
    !(btn_clean && strobe) |=> $stable(led));

  a_r2_single_move: assert property (@(posedge clk) disable iff (rst)
    (btn_clean && strobe) |=> (led == ($past(led) << 1)) || (led == ($past(led) >> 1)));

  a_r3_turn_top: assert property (@(posedge clk) disable iff (rst)
    (btn_clean && strobe && led == TOP) |=> led == (TOP >> 1));

  a_r3_turn_bottom: assert property (@(posedge clk) disable iff (rst)
    (btn_clean && strobe && led == BOT) |=> led == (BOT << 1));

  a_r5_strobe_pulse: assert property (@(posedge clk) disable iff (rst)
    strobe |=> !strobe);
endmodule

bind led_scan_top led_scan_checker #(.LED_W(LED_W)) u_led_scan_checker (
  .clk       (clk),
  .rst       (rst),
  .strobe    (strobe),
  .btn_clean (btn_clean),
  .led       (led)
);

// File: tb/led_scan_top_bench.sv
module led_scan_top_bench;
  localparam int CLK_PERIOD = 10;
  localparam int LED_W      = 8;
  localparam int TICK_MAX   = 4;
  localparam int STABLE_CNT = 3;
  localparam int PER        = TICK_MAX + 1;
  localparam int LAT        = STABLE_CNT + 5;
  localparam int SWEEP      = 2 * (LED_W - 1);

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             btn_raw = 1'b0;
  logic [LED_W-1:0] led;

  int total = 0;
  int bad   = 0;
  int edge_no = 0;
  int cycles  = 0;

  led_scan_top #(
    .LED_W(LED_W), .TICK_MAX(TICK_MAX), .STABLE_CNT(STABLE_CNT), .SYNC_STAGES(3)
  ) u_led_scan_top (
    .clk(clk), .rst(rst), .btn_raw(btn_raw), .led(led)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic tick();
    @(posedge clk);
    #1;
    edge_no++;
    cycles++;
  endtask

  function automatic logic [LED_W-1:0] pattern(input int steps);
    int p = steps % SWEEP;
    int idx = (p <= LED_W - 1) ? p : SWEEP - p;
    return LED_W'(1) << idx;
  endfunction

  function automatic int first_strobe(input int from);
    for (int n = from; n < from + PER + 1; n++)
      if (n >= PER + 1 && n % PER == 1) return n;
    return from;
  endfunction

  function automatic int steps_between(input int lo, input int hi);
    int c = 0;
    for (int m = lo; m <= hi; m++) if (m % PER == 1 && m >= PER + 1) c++;
    return c;
  endfunction

  task automatic check(input logic [LED_W-1:0] exp, input string req);
    total++;
    if (led !== exp) begin
      bad++;
      $display("FAIL %s edge=%0d actual=%h expected=%h", req, edge_no, led, exp);
    end
  endtask

  // steps happen on strobe edges in [n_lo, n_hi]; base is the step count before
  task automatic run_window(input int n_lo, input int n_hi, input int base,
                            input int len, input string req);
    for (int i = 0; i < len; i++) begin
      int hi_now;
      tick();
      hi_now = (edge_no < n_hi) ? edge_no : n_hi;
      check(pattern(base + steps_between(n_lo, hi_now)), req);
    end
  endtask

  initial begin : watchdog
    while (cycles < 20000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog expired actual=%0d expected<20000", cycles);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin : stim
    int k, n_first, n_last, done_steps;
    tick();
    tick();
    rst = 1'b0;
    edge_no = 0;
    check(LED_W'(1), "R1 reset value");

    // R6: pulses lasting exactly STABLE_CNT edges must be rejected
    for (int p = 0; p < 5; p++) begin
      btn_raw = 1'b1;
      for (int i = 0; i < STABLE_CNT; i++) begin tick(); check(LED_W'(1), "R6 short pulse"); end
      btn_raw = 1'b0;
      for (int i = 0; i < STABLE_CNT; i++) begin tick(); check(LED_W'(1), "R6 short pulse"); end
    end
    for (int i = 0; i < 20; i++) begin tick(); check(LED_W'(1), "R6 after bounce"); end

    // R2 R3 R5 R6: held press, full sweeps with exact step timing
    btn_raw = 1'b1;
    k = edge_no + 1;
    n_first = first_strobe(k + LAT);
    n_last  = 1 << 30;
    run_window(n_first, n_last, 0, 2 * SWEEP * PER + 30, "R3 sweep");

    // R4: release, stepping stops after the filter latency
    btn_raw = 1'b0;
    k = edge_no + 1;
    n_last = k + LAT - 1;
    run_window(n_first, n_last, 0, LAT + 60, "R4 hold after release");
    done_steps = steps_between(n_first, n_last);

    // R7: reset while pressed and stepping
    btn_raw = 1'b1;
    for (int i = 0; i < LAT + 3 * PER; i++) tick();
    rst = 1'b1;
    tick();
    check(LED_W'(1), "R7 reset priority");
    rst = 1'b0;
    edge_no = 0;
    if (done_steps == 0) check(LED_W'(0), "R4 steps before release");
    n_first = first_strobe(1 + LAT);
    run_window(n_first, 1 << 30, 0, n_first + 3 * PER, "R7 restart upward");

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule